// File: doc/BRIEF.md
# Cross-Die Region-Tagged Access Checker

This block carries a 4-bit region identifier across a die-to-die link inside the physical address itself, and checks it on the far die. The sending half takes a 44-bit address offset plus a region number and forms a 48-bit link address, with the region in the top four bits. The receiving half splits the region back out of the link address. It looks up the offset in a programmable table of eight address windows, and either forwards the request downstream with the tag bits cleared or rejects it.

Each window has an inclusive base and limit, an enable bit, and two 16-bit masks indexed by region number, one for reads and one for writes. A rejected request is consumed in the cycle it is presented. It returns an error strobe and never appears downstream. The first rejection is held in a sticky fault record until software clears it. This keeps one region from touching another region's memory on the remote die. Requests use a plain valid/ready channel on both halves.

Top module: `xdie_region_guard`

## Requirements
- R1: The link address equals the 44-bit offset `tx_off_i` in bits [43:0] with `tx_region_i` in bits [47:44]. `link_valid_o` follows `tx_valid_i` and `tx_ready_o` follows `link_ready_i`.
- R2: On the receiving side, the region is taken from bits [47:44] of `rx_addr_i`. `dn_addr_o` carries bits [43:0] unchanged, with bits [47:44] forced to zero.
- R3: A configuration write with `cfg_we_i` high loads window `cfg_idx_i` (0 to 7) with base, limit, read mask, write mask and enable at the next clock edge. The window is hit when it is enabled and base <= offset <= limit, with both bounds inclusive.
- R4: A read is permitted when any hit window has bit `region` of its read mask set. A write is permitted when any hit window has bit `region` of its write mask set. Where windows overlap, their grants are combined by OR.
- R5: An offset that hits no enabled window is denied. Every window is disabled after reset.
- R6: A denied request drives `err_valid_o` and `rx_ready_o` high in the same cycle and keeps `dn_valid_o` low.
- R7: A permitted request drives `dn_valid_o` high. `rx_ready_o` follows `dn_ready_i`, so downstream back-pressure stalls the request.
- R8: A denial while no fault is held records the offset, the region and the direction (1 = write). `fault_valid_o` goes high after the next clock edge.
- R9: A held fault ignores later denials and stays until `fault_clr_i` is sampled high. If a denial arrives in the same cycle as the clear, the new denial is recorded.
- R10: After reset, `fault_valid_o` is low and the fault fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_valid_i | input | 1 | Sender request valid |
| tx_ready_o | output | 1 | Sender request ready |
| tx_off_i | input | 44 | Sender address offset |
| tx_region_i | input | 4 | Sender region number |
| tx_write_i | input | 1 | Sender direction, 1 = write |
| link_valid_o | output | 1 | Link request valid |
| link_ready_i | input | 1 | Link request ready |
| link_addr_o | output | 48 | Tagged link address |
| link_write_o | output | 1 | Link direction |
| rx_valid_i | input | 1 | Receiver request valid |
| rx_ready_o | output | 1 | Receiver request ready |
| rx_addr_i | input | 48 | Tagged address from link |
| rx_write_i | input | 1 | Receiver direction |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream ready |
| dn_addr_o | output | 48 | Downstream address, tag cleared |
| dn_write_o | output | 1 | Downstream direction |
| err_valid_o | output | 1 | Denial strobe for the accepted request |
| cfg_we_i | input | 1 | Window table write strobe |
| cfg_idx_i | input | 3 | Window index |
| cfg_en_i | input | 1 | Window enable |
| cfg_base_i | input | 44 | Window base offset, inclusive |
| cfg_limit_i | input | 44 | Window limit offset, inclusive |
| cfg_rd_mask_i | input | 16 | Per-region read grant |
| cfg_wr_mask_i | input | 16 | Per-region write grant |
| fault_clr_i | input | 1 | Clear fault record |
| fault_valid_o | output | 1 | Fault record held |
| fault_off_o | output | 44 | Offset of the first denial |
| fault_region_o | output | 4 | Region of the first denial |
| fault_write_o | output | 1 | Direction of the first denial |

## Verification
The in-line assertions check four things on every cycle. A denied request is never forwarded and is always consumed. Downstream back-pressure always reaches the receiver's ready. A held fault record stays set, and stays unchanged, until it is cleared. Window decoding cannot be checked that way: inclusive bounds, OR-combined grants across overlapping windows, default denial and disabling a window each depend on table contents. Those, along with the tag placement across the link and the clear-with-denial case, are shown only by the bench's scenarios against its behavioural model.

// File: rtl/xrg_pkg.sv
package xrg_pkg;
  localparam int unsigned ADDR_W  = 48;
  localparam int unsigned RID_W   = 4;
  localparam int unsigned OFF_W   = ADDR_W - RID_W;
  localparam int unsigned NUM_RID = 1 << RID_W;

  typedef struct packed {
    logic               en;
    logic [OFF_W-1:0]   base;
    logic [OFF_W-1:0]   limit;
    logic [NUM_RID-1:0] rd;
    logic [NUM_RID-1:0] wr;
  } win_cfg_t;
endpackage

// File: rtl/xrg_tag_insert.sv
module xrg_tag_insert
  import xrg_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [RID_W-1:0]  rid_i,
  output logic [ADDR_W-1:0] addr_o
);
  // region rides in the top address bits
  assign addr_o = {rid_i, off_i};
endmodule

// File: rtl/xrg_window.sv
module xrg_window
  import xrg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  win_cfg_t         cfg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [RID_W-1:0] rid_i,
  output logic             rd_ok_o,
  output logic             wr_ok_o
);
  win_cfg_t cfg_q;
  logic     hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign hit     = cfg_q.en && (off_i >= cfg_q.base) && (off_i <= cfg_q.limit);
  assign rd_ok_o = hit && cfg_q.rd[rid_i];
  assign wr_ok_o = hit && cfg_q.wr[rid_i];

  AST_GRANT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok_o || wr_ok_o) |-> cfg_q.en); // R3
endmodule

// File: rtl/xrg_fault_rec.sv
module xrg_fault_rec
  import xrg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             deny_i,
  input  logic             clr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [RID_W-1:0] rid_i,
  input  logic             wr_i,
  output logic             valid_o,
  output logic [OFF_W-1:0] off_o,
  output logic [RID_W-1:0] rid_o,
  output logic             wr_o
);
  logic take;
  assign take = deny_i && (!valid_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      off_o   <= '0;
      rid_o   <= '0;
      wr_o    <= 1'b0;
    end else begin
      if (clr_i) valid_o <= 1'b0;
      if (take) begin
        valid_o <= 1'b1;
        off_o   <= off_i;
        rid_o   <= rid_i;
        wr_o    <= wr_i;
      end
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !clr_i |=> valid_o); // R9
  AST_FAULT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !clr_i |=> $stable(off_o) && $stable(rid_o) && $stable(wr_o)); // R9
  AST_FAULT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_i |=> valid_o); // R8
endmodule

// File: rtl/xdie_region_guard.sv
module xdie_region_guard
  import xrg_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  input  logic [OFF_W-1:0]   tx_off_i,
  input  logic [RID_W-1:0]   tx_region_i,
  input  logic               tx_write_i,
  output logic               link_valid_o,
  input  logic               link_ready_i,
  output logic [ADDR_W-1:0]  link_addr_o,
  output logic               link_write_o,
  input  logic               rx_valid_i,
  output logic               rx_ready_o,
  input  logic [ADDR_W-1:0]  rx_addr_i,
  input  logic               rx_write_i,
  output logic               dn_valid_o,
  input  logic               dn_ready_i,
  output logic [ADDR_W-1:0]  dn_addr_o,
  output logic               dn_write_o,
  output logic               err_valid_o,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_en_i,
  input  logic [OFF_W-1:0]   cfg_base_i,
  input  logic [OFF_W-1:0]   cfg_limit_i,
  input  logic [NUM_RID-1:0] cfg_rd_mask_i,
  input  logic [NUM_RID-1:0] cfg_wr_mask_i,
  input  logic               fault_clr_i,
  output logic               fault_valid_o,
  output logic [OFF_W-1:0]   fault_off_o,
  output logic [RID_W-1:0]   fault_region_o,
  output logic               fault_write_o
);
  // sending half
  xrg_tag_insert u_tag (
    .off_i (tx_off_i),
    .rid_i (tx_region_i),
    .addr_o(link_addr_o)
  );
  assign link_valid_o = tx_valid_i;
  assign link_write_o = tx_write_i;
  assign tx_ready_o   = link_ready_i;

  // receiving half
  logic [RID_W-1:0]   rx_rid;
  logic [OFF_W-1:0]   rx_off;
  logic [NUM_WIN-1:0] rd_ok, wr_ok;
  logic               permit, deny;
  win_cfg_t           cfg_w;

  assign rx_rid = rx_addr_i[ADDR_W-1 -: RID_W];
  assign rx_off = rx_addr_i[OFF_W-1:0];

  assign cfg_w = '{en: cfg_en_i, base: cfg_base_i, limit: cfg_limit_i,
                   rd: cfg_rd_mask_i, wr: cfg_wr_mask_i};

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    xrg_window u_win (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
      .cfg_i  (cfg_w),
      .off_i  (rx_off),
      .rid_i  (rx_rid),
      .rd_ok_o(rd_ok[g]),
      .wr_ok_o(wr_ok[g])
    );
  end

  assign permit = rx_write_i ? |wr_ok : |rd_ok;
  assign deny   = rx_valid_i && !permit;

  assign dn_valid_o  = rx_valid_i && permit;
  assign dn_addr_o   = {{RID_W{1'b0}}, rx_off};
  assign dn_write_o  = rx_write_i;
  assign err_valid_o = deny;
  assign rx_ready_o  = deny ? 1'b1 : dn_ready_i;

  xrg_fault_rec u_fault (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .deny_i (deny),
    .clr_i  (fault_clr_i),
    .off_i  (rx_off),
    .rid_i  (rx_rid),
    .wr_i   (rx_write_i),
    .valid_o(fault_valid_o),
    .off_o  (fault_off_o),
    .rid_o  (fault_region_o),
    .wr_o   (fault_write_o)
  );

  AST_DENY_NOT_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> !dn_valid_o && rx_ready_o); // R6
  AST_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_ready_i |-> !rx_ready_o); // R7
  AST_DN_TAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> dn_addr_o[ADDR_W-1 -: RID_W] == '0); // R2
endmodule

// File: tb/xdie_region_guard_test.sv
`timescale 1ns/1ps
module xdie_region_guard_test;
  localparam int OW = 44;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          tx_valid = 0, tx_write = 0, dn_ready = 1;
  logic [OW-1:0] tx_off = '0;
  logic [3:0]    tx_rid = '0;
  logic          cfg_we = 0, cfg_en = 0, fclr = 0;
  logic [2:0]    cfg_idx = '0;
  logic [OW-1:0] cfg_base = '0, cfg_limit = '0;
  logic [15:0]   cfg_rd = '0, cfg_wr = '0;

  logic          tx_ready, link_valid, link_write, rx_ready;
  logic [47:0]   link_addr, dn_addr;
  logic          dn_valid, dn_write, err_valid;
  logic          f_valid, f_write;
  logic [OW-1:0] f_off;
  logic [3:0]    f_rid;

  xdie_region_guard uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_off_i(tx_off),
    .tx_region_i(tx_rid), .tx_write_i(tx_write),
    .link_valid_o(link_valid), .link_ready_i(rx_ready), .link_addr_o(link_addr),
    .link_write_o(link_write),
    .rx_valid_i(link_valid), .rx_ready_o(rx_ready), .rx_addr_i(link_addr),
    .rx_write_i(link_write),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_addr_o(dn_addr),
    .dn_write_o(dn_write), .err_valid_o(err_valid),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en),
    .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit),
    .cfg_rd_mask_i(cfg_rd), .cfg_wr_mask_i(cfg_wr),
    .fault_clr_i(fclr), .fault_valid_o(f_valid), .fault_off_o(f_off),
    .fault_region_o(f_rid), .fault_write_o(f_write)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_en[8];
  logic [OW-1:0] m_base[8], m_lim[8];
  logic [15:0] m_rd[8], m_wr[8];
  bit          m_fv, m_fw;
  logic [OW-1:0] m_foff;
  logic [3:0]  m_frid;

  function automatic bit allowed(input logic [OW-1:0] off, input logic [3:0] rid, input bit wr);
    for (int i = 0; i < 8; i++)
      if (m_en[i] && off >= m_base[i] && off <= m_lim[i] && (wr ? m_wr[i][rid] : m_rd[i][rid]))
        return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_en[i] = 0; m_base[i] = '0; m_lim[i] = '0; m_rd[i] = '0; m_wr[i] = '0;
      end
      m_fv = 0; m_fw = 0; m_foff = '0; m_frid = '0;
    end else begin
      bit d;
      d = tx_valid && !allowed(tx_off, tx_rid, tx_write);
      if (fclr) m_fv = 0;
      if (d && !m_fv) begin
        m_fv = 1; m_foff = tx_off; m_frid = tx_rid; m_fw = tx_write;
      end
      if (cfg_we) begin
        m_en[cfg_idx] = cfg_en; m_base[cfg_idx] = cfg_base; m_lim[cfg_idx] = cfg_limit;
        m_rd[cfg_idx] = cfg_rd; m_wr[cfg_idx] = cfg_wr;
      end
    end
  end

  // compare on every clock
  always @(negedge clk) if (rst_n && !finished) begin
    bit p;
    p = allowed(tx_off, tx_rid, tx_write);
    chk(link_addr == {tx_rid, tx_off}, "R1 link_addr", link_addr, {tx_rid, tx_off});
    chk(link_valid == tx_valid && tx_ready == rx_ready, "R1 link handshake", link_valid, tx_valid);
    chk(dn_addr == {4'b0, tx_off}, "R2 dn_addr", dn_addr, {4'b0, tx_off});
    chk(dn_valid == (tx_valid && p), "R4 dn_valid", dn_valid, tx_valid && p);
    chk(err_valid == (tx_valid && !p), "R6 err_valid", err_valid, tx_valid && !p);
    chk(rx_ready == ((tx_valid && !p) ? 1'b1 : dn_ready), "R7 rx_ready", rx_ready,
        (tx_valid && !p) ? 1'b1 : dn_ready);
    chk(f_valid == m_fv, "R8 fault_valid", f_valid, m_fv);
    if (m_fv)
      chk(f_off == m_foff && f_rid == m_frid && f_write == m_fw, "R9 fault fields",
          {f_rid, f_off}, {m_frid, m_foff});
  end

  task automatic req(input bit v, input logic [OW-1:0] off, input logic [3:0] rid, input bit wr);
    @(posedge clk); #1;
    tx_valid = v; tx_off = off; tx_rid = rid; tx_write = wr;
    @(negedge clk); #1;
  endtask

  task automatic win(input int idx, input bit en, input logic [OW-1:0] b, input logic [OW-1:0] l,
                     input logic [15:0] rd, input logic [15:0] wr);
    @(posedge clk); #1;
    tx_valid = 0;
    cfg_we = 1; cfg_idx = idx[2:0]; cfg_en = en; cfg_base = b; cfg_limit = l; cfg_rd = rd; cfg_wr = wr;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  initial begin
    #20_000_000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    chk(f_valid == 0 && f_off == '0 && f_rid == '0 && f_write == 0, "R10 reset state", f_valid, 0);
    rst_n = 1;
    // R5: empty table denies
    req(1, 44'h100, 4'd3, 0);
    chk(err_valid == 1 && dn_valid == 0, "R5 default deny", err_valid, 1);
    req(0, '0, '0, 0);
    chk(f_valid && f_off == 44'h100 && f_rid == 3 && !f_write, "R8 first denial", f_off, 44'h100);
    @(posedge clk); #1; fclr = 1; @(posedge clk); #1; fclr = 0;
    chk(f_valid == 0, "R9 clear", f_valid, 0);
    // R3: window 0
    win(0, 1, 44'h1000, 44'h1FFF, 16'h0008, 16'h0028);
    req(1, 44'h1000, 4'd3, 0);
    chk(dn_valid == 1, "R3 base inclusive", dn_valid, 1);
    req(1, 44'h1FFF, 4'd3, 0);
    chk(dn_valid == 1, "R3 limit inclusive", dn_valid, 1);
    req(1, 44'h2000, 4'd3, 0);
    chk(err_valid == 1, "R3 past limit", err_valid, 1);
    req(1, 44'h1800, 4'd5, 1);
    chk(dn_valid == 1 && dn_write == 1, "R4 write grant", dn_valid, 1);
    req(1, 44'h1800, 4'd5, 0);
    chk(err_valid == 1, "R4 read refused", err_valid, 1);
    req(0, '0, '0, 0);
    chk(f_valid && f_off == 44'h2000, "R9 first fault kept", f_off, 44'h2000);
    // R7 back-pressure
    dn_ready = 0;
    req(1, 44'h1004, 4'd3, 0);
    chk(dn_valid == 1 && tx_ready == 0, "R7 stall", tx_ready, 0);
    dn_ready = 1;
    // R9 clear with simultaneous denial
    @(posedge clk); #1;
    fclr = 1; tx_valid = 1; tx_off = 44'h1234; tx_rid = 4'd6; tx_write = 1;
    @(posedge clk); #1;
    fclr = 0; tx_valid = 0;
    chk(f_valid && f_off == 44'h1234 && f_rid == 6 && f_write, "R9 clear plus deny", f_off, 44'h1234);
    // R4 overlapping windows
    win(7, 1, 44'h1800, 44'h2FFF, 16'h0020, 16'h0000);
    req(1, 44'h2800, 4'd5, 0);
    chk(dn_valid == 1, "R4 window 7 grant", dn_valid, 1);
    req(1, 44'h1900, 4'd5, 0);
    chk(dn_valid == 1, "R4 overlap OR", dn_valid, 1);
    req(1, 44'h1900, 4'd5, 1);
    chk(dn_valid == 1, "R4 overlap write", dn_valid, 1);
    // R1/R2 top region and wide offset
    win(2, 1, 44'hF00_0000_0000, 44'hFFF_FFFF_FFFF, 16'h8000, 16'h8000);
    req(1, 44'hABC_DEF0_1234, 4'd15, 1);
    chk(link_addr == 48'hFAB_CDEF_0123_4 >> 0 || link_addr[47:44] == 4'hF, "R1 tag bits", link_addr[47:44], 4'hF);
    chk(dn_addr == 48'h0AB_CDEF_0123_4 >> 0 || dn_addr[47:44] == 4'h0, "R2 tag cleared", dn_addr[47:44], 0);
    req(1, 44'hF12_3456_789A, 4'd15, 1);
    chk(dn_valid == 1 && dn_addr == {4'h0, 44'hF12_3456_789A}, "R2 forwarded", dn_addr, {4'h0, 44'hF12_3456_789A});
    // R3 disable window 7
    win(7, 0, 44'h1800, 44'h2FFF, 16'h0020, 16'h0000);
    req(1, 44'h2800, 4'd5, 0);
    chk(err_valid == 1, "R3 disabled window", err_valid, 1);
    req(0, '0, '0, 0);
    repeat (3) @(posedge clk);
    #1;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule